// File: doc/BRIEF.md
# Byte-wide memory bus controller

This block is the memory side of a small 8-bit processor whose external bus carries 8 data bits and 16 address bits. It owns two registers. An address register drives the address pins directly. A data register sits between the processor's internal byte bus and the external data pins. The instruction decoder steers the block with a 3-bit command each cycle. The commands set the address one byte at a time or all at once from a chosen 16-bit register, latch a byte for writing, run a read or write strobe, or fetch an instruction together with its operand bytes from the program counter.

The strobes are timed so that the address never moves while one of them is active. For a write, the external data driver is switched on before the write strobe rises, and the data stays constant for the whole strobe. During a fetch the block emits one increment pulse for each byte it reads. It then reloads the address from the advanced program counter before it reads the next byte. While a read, write or fetch is in progress the block reports busy and discards any new command.

Top module: `membus_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the address and data registers are zero and rd_o, wr_o, doe_o, busy_o, rvalid_o, fetch_valid_o and pc_inc_o are low.
- R2: Command 1 (load-low) writes idata_i into address bits 7:0. Command 2 (load-high) writes it into bits 15:8. In both cases the other byte is kept, the change is visible on addr_o after one clock edge, and busy_o stays low.
- R3: Command 3 (load-full) copies a whole 16-bit source into the address in one edge. src_sel_i chooses the source: 0 for bc_i, 1 for pc_i, 2 for sp_i, 3 for dd_i.
- R4: Command 5 (read) raises rd_o for exactly one cycle, starting at the edge after the command. The edge that ends the pulse captures ext_din_i into the data register, which appears on rdata_o, and rvalid_o is high for that one following cycle.
- R5: Command 4 (latch) copies idata_i into the data register, shown on both dout_o and rdata_o after one edge, without raising rd_o, wr_o or doe_o.
- R6: Command 6 (write) raises doe_o at the edge after the command. wr_o rises WR_SETUP cycles later and stays high for WR_WIDTH cycles. dout_o does not change from the command until wr_o falls, and doe_o falls on the same edge as wr_o.
- R7: doe_o is low whenever no write is in progress, so the external data pins are left undriven.
- R8: addr_o does not change during an rd_o or wr_o pulse. Every command other than 0 (none) is ignored while busy_o is high.
- R9: Command 7 (fetch) loads the address from pc_i and then reads 1 + L bytes, where L is fetch_len_i and the value 3 is treated as 2. Each byte is reported with fetch_valid_o, fetch_idx_o (0 for the opcode, 1 and 2 for the operands) and a one-cycle pc_inc_o. The address is reloaded from the advanced pc_i before each later read.
- R10: busy_o is high from the edge that accepts a read, write or fetch up to the edge that completes it. It is low for the load and latch commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command from the decoder (0 none, 1 load-low, 2 load-high, 3 load-full, 4 latch, 5 read, 6 write, 7 fetch) |
| src_sel_i | input | 2 | Source for load-full: 0 BC, 1 PC, 2 SP, 3 DD |
| fetch_len_i | input | 2 | Operand byte count for fetch (3 treated as 2) |
| idata_i | input | 8 | Internal data bus into the block |
| bc_i | input | 16 | BC register pair value |
| pc_i | input | 16 | Program counter value |
| sp_i | input | 16 | Stack pointer value |
| dd_i | input | 16 | DD shadow register value |
| ext_din_i | input | 8 | Byte read from the external data pins |
| addr_o | output | 16 | External address bus |
| dout_o | output | 8 | Byte for the external data pins |
| doe_o | output | 1 | Enable for the external data driver (low means high impedance) |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| rdata_o | output | 8 | Data register onto the internal bus |
| rvalid_o | output | 1 | rdata_o holds a freshly read byte |
| busy_o | output | 1 | A read, write or fetch is in progress |
| fetch_valid_o | output | 1 | A fetched byte is on rdata_o |
| fetch_idx_o | output | 2 | Position of that byte within the instruction |
| pc_inc_o | output | 1 | Request to advance the program counter |

## Verification
A wrong sequencer state shows up on the strobes within one or two cycles. Symptoms include a read strobe lasting two cycles, a write strobe without the driver enabled, or busy_o disagreeing with the strobes. A corrupted address register is seen on addr_o at the next edge and in the byte the bench memory returns on the following read. A data register that changes when it should not shows on dout_o during the write pulse, or on rdata_o right after a read. A fetch counter error appears as a wrong fetch_idx_o, a missing or extra pc_inc_o, or an address that does not follow the bench's program counter.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [2:0] {
    MB_NONE   = 3'd0,
    MB_LDLO   = 3'd1,
    MB_LDHI   = 3'd2,
    MB_LDFULL = 3'd3,
    MB_LATCH  = 3'd4,
    MB_READ   = 3'd5,
    MB_WRITE  = 3'd6,
    MB_FETCH  = 3'd7
  } mb_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD    = 3'd1,
    S_WSET  = 3'd2,
    S_WPUL  = 3'd3,
    S_FRD   = 3'd4,
    S_FINC  = 3'd5,
    S_FLOAD = 3'd6
  } mb_state_e;

  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_SRC = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SRC_PC = 2'd1;
endpackage

// File: rtl/mb_addr_reg.sv
module mb_addr_reg
  import membus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_lo,
  input  logic                          ld_hi,
  input  logic                          ld_full,
  input  logic [SEL_W-1:0]              full_sel,
  input  logic [DW-1:0]                 byte_in,
  input  logic [NUM_SRC-1:0][AW-1:0]    srcs,
  output logic [AW-1:0]                 addr_q
);
  localparam int HB = AW - DW;

  logic [AW-1:0] full_val;
  logic [AW-1:0] addr_d;

  assign full_val = srcs[full_sel];

  always_comb begin
    addr_d = addr_q;
    if (ld_full)    addr_d = full_val;
    else if (ld_lo) addr_d[DW-1:0] = byte_in;
    else if (ld_hi) addr_d[AW-1:DW] = byte_in[HB-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end

  // R2: a low-byte load leaves the high byte untouched
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !ld_full) |=> addr_q[AW-1:DW] == $past(addr_q[AW-1:DW]));
  // R2: a high-byte load leaves the low byte untouched
  a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !ld_full && !ld_lo) |=> addr_q[DW-1:0] == $past(addr_q[DW-1:0]));
  // R3: a full load takes the selected source
  a_r3_full_src: assert property (@(posedge clk) disable iff (rst)
    ld_full |=> addr_q == $past(full_val));
endmodule

// File: rtl/mb_data_reg.sv
module mb_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_int,
  input  logic          ld_ext,
  input  logic [DW-1:0] int_in,
  input  logic [DW-1:0] ext_in,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst)         data_q <= '0;
    else if (ld_ext) data_q <= ext_in;
    else if (ld_int) data_q <= int_in;
  end

  // R5/R6: the register only moves when told to
  a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld_int && !ld_ext) |=> $stable(data_q));
endmodule

// File: rtl/mb_seq.sv
module mb_seq
  import membus_pkg::*;
#(
  parameter int WR_SETUP = 1,
  parameter int WR_WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  mb_cmd_e          cmd,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [1:0]       fetch_len,
  output logic             ld_lo,
  output logic             ld_hi,
  output logic             ld_full,
  output logic [SEL_W-1:0] full_sel,
  output logic             ld_int,
  output logic             ld_ext,
  output logic             rd_o,
  output logic             wr_o,
  output logic             doe_o,
  output logic             busy_o,
  output logic             rvalid_o,
  output logic             fetch_valid_o,
  output logic [1:0]       fetch_idx_o,
  output logic             pc_inc_o
);
  localparam int CMAX = (WR_SETUP > WR_WIDTH) ? WR_SETUP : WR_WIDTH;
  localparam int CW   = (CMAX < 2) ? 1 : $clog2(CMAX + 1);
  localparam logic [CW-1:0] SET_LOAD = CW'(WR_SETUP - 1);
  localparam logic [CW-1:0] WID_LOAD = CW'(WR_WIDTH - 1);

  mb_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [1:0]     left_q, left_d;
  logic [1:0]     idx_q, idx_d;
  logic [1:0]     len_c;
  logic           rd_d, wr_d, doe_d, rv_d, fv_d, inc_d;
  logic           idle;

  assign idle  = (st_q == S_IDLE);
  assign len_c = (fetch_len == 2'd3) ? 2'd2 : fetch_len;

  // register loads, decided in the cycle they take effect
  always_comb begin
    ld_lo    = 1'b0;
    ld_hi    = 1'b0;
    ld_full  = 1'b0;
    ld_int   = 1'b0;
    ld_ext   = 1'b0;
    full_sel = SRC_PC;
    unique case (st_q)
      S_IDLE: begin
        ld_lo   = (cmd == MB_LDLO);
        ld_hi   = (cmd == MB_LDHI);
        ld_int  = (cmd == MB_LATCH);
        ld_full = (cmd == MB_LDFULL) || (cmd == MB_FETCH);
        if (cmd == MB_LDFULL) full_sel = src_sel;
      end
      S_RD, S_FRD: ld_ext  = 1'b1;
      S_FLOAD:     ld_full = 1'b1;
      default: ;
    endcase
  end

  // next state and next registered strobes
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    idx_d  = idx_q;
    rd_d   = 1'b0;
    wr_d   = 1'b0;
    doe_d  = 1'b0;
    rv_d   = 1'b0;
    fv_d   = 1'b0;
    inc_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd == MB_READ) begin
          st_d = S_RD;
          rd_d = 1'b1;
        end else if (cmd == MB_WRITE) begin
          st_d  = S_WSET;
          cnt_d = SET_LOAD;
          doe_d = 1'b1;
        end else if (cmd == MB_FETCH) begin
          st_d   = S_FRD;
          rd_d   = 1'b1;
          left_d = len_c;
          idx_d  = 2'd0;
        end
      end
      S_RD: begin
        st_d = S_IDLE;
        rv_d = 1'b1;
      end
      S_WSET: begin
        doe_d = 1'b1;
        if (cnt_q == '0) begin
          st_d  = S_WPUL;
          cnt_d = WID_LOAD;
          wr_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_WPUL: begin
        if (cnt_q == '0) begin
          st_d = S_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
          wr_d  = 1'b1;
          doe_d = 1'b1;
        end
      end
      S_FRD: begin
        st_d  = S_FINC;
        rv_d  = 1'b1;
        fv_d  = 1'b1;
        inc_d = 1'b1;
      end
      S_FINC: begin
        if (left_q == 2'd0) begin
          st_d = S_IDLE;
        end else begin
          st_d   = S_FLOAD;
          left_d = left_q - 1'b1;
          idx_d  = idx_q + 1'b1;
        end
      end
      S_FLOAD: begin
        st_d = S_FRD;
        rd_d = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= S_IDLE;
      cnt_q         <= '0;
      left_q        <= '0;
      idx_q         <= '0;
      rd_o          <= 1'b0;
      wr_o          <= 1'b0;
      doe_o         <= 1'b0;
      busy_o        <= 1'b0;
      rvalid_o      <= 1'b0;
      fetch_valid_o <= 1'b0;
      pc_inc_o      <= 1'b0;
    end else begin
      st_q          <= st_d;
      cnt_q         <= cnt_d;
      left_q        <= left_d;
      idx_q         <= idx_d;
      rd_o          <= rd_d;
      wr_o          <= wr_d;
      doe_o         <= doe_d;
      busy_o        <= (st_d != S_IDLE);
      rvalid_o      <= rv_d;
      fetch_valid_o <= fv_d;
      pc_inc_o      <= inc_d;
    end
  end

  assign fetch_idx_o = idx_q;

  // R4: read strobe lasts one cycle
  a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_o |=> !rd_o);
  // R6: write strobe only with the driver on
  a_r6_wr_with_oe: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> doe_o);
  // R6: driver enabled at least a cycle before the strobe rises
  a_r6_oe_before_wr: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_o) |-> $past(doe_o));
  // R7: pins undriven when idle
  a_r7_idle_hiz: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !doe_o);
  // R9: one increment per fetched byte
  a_r9_inc_with_byte: assert property (@(posedge clk) disable iff (rst)
    pc_inc_o |-> fetch_valid_o);
  // R10: strobes only while busy
  a_r10_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> busy_o);
  // R4/R6: never read and write together
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 16,
  parameter int WR_SETUP = 1,
  parameter int WR_WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_i,
  input  logic [1:0]       src_sel_i,
  input  logic [1:0]       fetch_len_i,
  input  logic [DW-1:0]    idata_i,
  input  logic [AW-1:0]    bc_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    dd_i,
  input  logic [DW-1:0]    ext_din_i,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    dout_o,
  output logic             doe_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             busy_o,
  output logic             fetch_valid_o,
  output logic [1:0]       fetch_idx_o,
  output logic             pc_inc_o
);
  logic                       ld_lo, ld_hi, ld_full, ld_int, ld_ext;
  logic [SEL_W-1:0]           full_sel;
  logic [NUM_SRC-1:0][AW-1:0] srcs;
  logic [DW-1:0]              dreg;

  assign srcs = {dd_i, sp_i, pc_i, bc_i};

  mb_seq #(.WR_SETUP(WR_SETUP), .WR_WIDTH(WR_WIDTH)) u_seq (
    .clk(clk), .rst(rst), .cmd(mb_cmd_e'(cmd_i)), .src_sel(src_sel_i),
    .fetch_len(fetch_len_i), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_full(ld_full),
    .full_sel(full_sel), .ld_int(ld_int), .ld_ext(ld_ext), .rd_o(rd_o),
    .wr_o(wr_o), .doe_o(doe_o), .busy_o(busy_o), .rvalid_o(rvalid_o),
    .fetch_valid_o(fetch_valid_o), .fetch_idx_o(fetch_idx_o), .pc_inc_o(pc_inc_o)
  );

  mb_addr_reg #(.DW(DW), .AW(AW)) u_addr (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_full(ld_full),
    .full_sel(full_sel), .byte_in(idata_i), .srcs(srcs), .addr_q(addr_o)
  );

  mb_data_reg #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .ld_int(ld_int), .ld_ext(ld_ext),
    .int_in(idata_i), .ext_in(ext_din_i), .data_q(dreg)
  );

  assign dout_o  = dreg;
  assign rdata_o = dreg;

  // R8: address frozen across every strobe
  a_r8_addr_rd: assert property (@(posedge clk) disable iff (rst)
    rd_o |=> $stable(addr_o));
  a_r8_addr_wr: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> $stable(addr_o));
  // R6: data constant while the write strobe is high
  a_r6_dout_wr: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> $stable(dout_o));
  // R8: no load while busy
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !rd_o && !fetch_valid_o) |=> $stable(addr_o) || $past(ld_full));
endmodule

// File: tb/membus_ctrl_test.sv
module membus_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_SETUP   = 2;
  localparam int TB_WIDTH   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  sel = 2'd0;
  logic [1:0]  flen = 2'd0;
  logic [7:0]  idata = 8'd0;
  logic [15:0] bc = 16'h0, sp = 16'h0, dd = 16'h0, pc_base = 16'h0;
  logic [15:0] inc_cnt;
  logic [15:0] pc;
  logic [7:0]  ext_din;
  logic [15:0] addr;
  logic [7:0]  dout, rdata;
  logic        doe, rd, wr, rvalid, busy, fvalid, pcinc;
  logic [1:0]  fidx;

  int errors = 0;
  int checks = 0;
  logic [15:0] addr_m;
  logic [7:0]  data_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign ext_din = mem_f(addr);
  assign pc = pc_base + inc_cnt;

  always @(posedge clk) begin
    if (rst) inc_cnt <= 16'd0;
    else if (pcinc) inc_cnt <= inc_cnt + 16'd1;
  end

  membus_ctrl #(.WR_SETUP(TB_SETUP), .WR_WIDTH(TB_WIDTH)) uut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .src_sel_i(sel), .fetch_len_i(flen),
    .idata_i(idata), .bc_i(bc), .pc_i(pc), .sp_i(sp), .dd_i(dd),
    .ext_din_i(ext_din), .addr_o(addr), .dout_o(dout), .doe_o(doe),
    .rd_o(rd), .wr_o(wr), .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy),
    .fetch_valid_o(fvalid), .fetch_idx_o(fidx), .pc_inc_o(pcinc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // drive one command for one edge, return at the negedge after it
  task automatic issue(input logic [2:0] c);
    cmd = c;
    @(posedge clk);
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic do_ld(input logic [2:0] c, input logic [7:0] v);
    idata = v;
    issue(c);
    if (c == 3'd1) addr_m[7:0] = v; else addr_m[15:8] = v;
    chk("R2 addr after byte load", addr, addr_m);
    chk("R10 no busy on load", busy, 0);
  endtask

  task automatic do_full(input logic [1:0] s);
    sel = s;
    issue(3'd3);
    case (s)
      2'd0: addr_m = bc;
      2'd1: addr_m = pc;
      2'd2: addr_m = sp;
      default: addr_m = dd;
    endcase
    chk("R3 full load", addr, addr_m);
  endtask

  task automatic do_latch(input logic [7:0] v);
    idata = v;
    issue(3'd4);
    data_m = v;
    chk("R5 dout latched", dout, data_m);
    chk("R5 no strobe", {rd, wr, doe}, 0);
  endtask

  task automatic do_read(input bit disturb);
    issue(3'd5);
    chk("R4 rd high", rd, 1);
    chk("R10 busy in read", busy, 1);
    if (disturb) begin
      idata = ~addr_m[7:0];
      cmd = 3'd1;
    end
    @(negedge clk);
    cmd = 3'd0;
    data_m = mem_f(addr_m);
    chk("R4 rd ended", rd, 0);
    chk("R4 rvalid", rvalid, 1);
    chk("R4 captured byte", rdata, data_m);
    chk("R8 addr kept", addr, addr_m);
    chk("R10 busy cleared", busy, 0);
    @(negedge clk);
    chk("R4 rvalid one cycle", rvalid, 0);
    chk("R8 ignored load-low", addr, addr_m);
  endtask

  task automatic do_write(input bit disturb);
    issue(3'd6);
    for (int k = 0; k < TB_SETUP; k++) begin
      chk("R6 oe during setup", doe, 1);
      chk("R6 wr low during setup", wr, 0);
      chk("R7 busy in write", busy, 1);
      if (disturb && k == 0) begin
        idata = ~data_m;
        cmd = 3'd4;
      end
      @(negedge clk);
      cmd = 3'd0;
    end
    for (int k = 0; k < TB_WIDTH; k++) begin
      chk("R6 wr pulse", wr, 1);
      chk("R6 oe in pulse", doe, 1);
      chk("R6 dout held", dout, data_m);
      chk("R8 addr in pulse", addr, addr_m);
      @(negedge clk);
    end
    chk("R6 wr fell", wr, 0);
    chk("R7 bus released", doe, 0);
    chk("R10 busy cleared", busy, 0);
    chk("R8 latch ignored", dout, data_m);
  endtask

  task automatic do_fetch(input logic [1:0] l);
    int n;
    n = (l == 2'd3) ? 3 : int'(l) + 1;
    flen = l;
    issue(3'd7);
    for (int b = 0; b < n; b++) begin
      chk("R9 rd at pc", {rd, addr}, {1'b1, pc});
      addr_m = pc;
      @(negedge clk);
      chk("R9 byte flagged", {fvalid, pcinc, rvalid}, 3'b111);
      chk("R9 byte index", fidx, b);
      chk("R9 byte value", rdata, mem_f(addr_m));
      data_m = mem_f(addr_m);
      @(negedge clk);
      chk("R9 inc one cycle", {pcinc, fvalid, rd}, 0);
      if (b == n - 1) chk("R10 fetch done", busy, 0);
      else begin
        chk("R10 busy mid fetch", busy, 1);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk("R1 outputs in reset", {rd, wr, doe, busy, rvalid, fvalid, pcinc}, 0);
    chk("R1 addr in reset", addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {addr, dout, rd, wr, doe, busy}, 0);
    addr_m = 16'h0;
    data_m = 8'h0;
    bc = 16'h1234; sp = 16'h0FFF; dd = 16'hBEEF; pc_base = 16'hF000;
    // directed corners
    do_full(2'd0); do_full(2'd1); do_full(2'd2); do_full(2'd3);
    do_ld(3'd1, 8'hA5);
    do_ld(3'd2, 8'h3C);
    do_read(1'b1);
    do_latch(8'h96);
    do_write(1'b1);
    do_fetch(2'd0);
    do_fetch(2'd1);
    do_fetch(2'd2);
    do_fetch(2'd3);
    // random mix
    for (int it = 0; it < 300; it++) begin
      bc = 16'($urandom); sp = 16'($urandom); dd = 16'($urandom);
      case ($urandom_range(0, 6))
        0: do_ld(3'd1, 8'($urandom));
        1: do_ld(3'd2, 8'($urandom));
        2: do_full(2'($urandom));
        3: do_latch(8'($urandom));
        4: do_read(1'($urandom));
        5: do_write(1'($urandom));
        default: do_fetch(2'($urandom));
      endcase
    end
    finish_up();
  end
endmodule